// File: doc/BRIEF.md
# Sync-Framed Serial Parity Checker

This block watches a serial stream of slots. In each clock cycle it receives a valid strobe, a sync indication and one data bit. A valid sync slot opens a frame. The next `FRAME_BITS` valid data slots form that frame's payload. While the frame is open, the block tracks the payload position and whether the count of ones so far is odd or even.

When the last payload slot arrives, the block raises a frame-done pulse for one cycle. If the payload holds an odd number of ones, an error pulse is raised in the same cycle, because the frame must carry even parity. After the last slot, the block goes back to waiting for the next sync. A sync that arrives while a frame is open discards that frame without any report and starts a new one.

Top module: `framed_parity_chk`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `done_o` and `err_o` low, and no frame is open.
- R2: After reset, data slots that arrive before the first valid sync slot do not produce a `done_o` or `err_o` pulse.
- R3: A slot with `in_valid`=1 and `in_sync`=1 opens a frame. The bit of that slot is not payload. After the `FRAME_BITS`-th following slot with `in_valid`=1 and `in_sync`=0, `done_o` is high for exactly the one cycle after the clock edge that sampled that slot.
- R4: At the end of a frame, `err_o` is 1 when the frame's payload bits hold an odd number of ones and 0 when they hold an even number. This is an even parity rule.
- R5: `err_o` is never high unless `done_o` is high in the same cycle.
- R6: Slots with `in_valid`=0 neither advance the frame position nor change the parity, whatever `in_bit` and `in_sync` carry.
- R7: A valid sync slot while a frame is open discards that frame without a `done_o` or `err_o` pulse, and starts a new frame with zero position and even parity. This also holds when the sync slot falls where the last payload slot was due.
- R8: Once a frame ends, data slots that arrive before the next valid sync produce no `done_o` or `err_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slot strobe; low means the cycle carries no slot |
| in_sync | input | 1 | Frame-start marker, used only when `in_valid` is high |
| in_bit | input | 1 | Payload bit of a data slot |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| err_o | output | 1 | One-cycle pulse when a completed frame fails even parity |

## Verification
The bench targets several corner cases:
- A stream that starts with data before any sync. A design that is armed out of reset would report a phantom frame here.
- Idle gaps inside a frame. A design that counts every cycle would finish early and report the wrong parity.
- A resync that lands on the last payload slot. A design that lets data win over sync would emit a done pulse for a frame that was abandoned.
- Stray bits after a frame ends. A design that does not return to waiting would report a second frame.

Random streams with sparse syncs and strobes cover the parity outcome under many bit patterns.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_SYNC = 2'd1,
    SLOT_DATA = 2'd2
  } slot_kind_e;

  function automatic slot_kind_e classify_slot(input logic valid, input logic sync);
    if (!valid)    return SLOT_NONE;
    else if (sync) return SLOT_SYNC;
    else           return SLOT_DATA;
  endfunction

endpackage

// File: rtl/fp_slot_counter.sv
module fp_slot_counter
  import fp_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  slot_kind_e kind,
  output logic       open_o,
  output logic       last_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic [CW-1:0] pos_q;
  logic          open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      unique case (kind)
        SLOT_SYNC: begin
          open_q <= 1'b1;
          pos_q  <= '0;
        end
        SLOT_DATA: begin
          if (open_q) begin
            if (pos_q == LAST_POS) begin
              open_q <= 1'b0;
              pos_q  <= '0;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign open_o = open_q;
  assign last_o = open_q && (pos_q == LAST_POS);

endmodule

// File: rtl/fp_parity_track.sv
module fp_parity_track
  import fp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slot_kind_e kind,
  input  logic       open_i,
  input  logic       bit_i,
  output logic       odd_o
);
  logic odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q <= 1'b0;
    end else if (kind == SLOT_SYNC) begin
      odd_q <= 1'b0;
    end else if (kind == SLOT_DATA && open_i) begin
      odd_q <= odd_q ^ bit_i;
    end
  end

  assign odd_o = odd_q;

endmodule

// File: rtl/framed_parity_chk.sv
module framed_parity_chk
  import fp_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sync,
  input  logic in_bit,
  output logic done_o,
  output logic err_o
);
  slot_kind_e kind;
  logic       open_w;
  logic       last_w;
  logic       odd_w;
  logic       finish_w;

  assign kind = classify_slot(in_valid, in_sync);

  fp_slot_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .open_o (open_w),
    .last_o (last_w)
  );

  fp_parity_track u_par (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .open_i (open_w),
    .bit_i  (in_bit),
    .odd_o  (odd_w)
  );

  assign finish_w = (kind == SLOT_DATA) && last_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= finish_w;
      err_o  <= finish_w && (odd_w ^ in_bit);
    end
  end

endmodule

// File: rtl/fp_parity_chk_sva.sv
module fp_parity_chk_sva (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_sync,
  input logic done_o,
  input logic err_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!done_o && !err_o));

  a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_gap_no_done: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !done_o);

  a_r7_sync_no_done: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sync) |=> (!done_o && !err_o));

endmodule

bind framed_parity_chk fp_parity_chk_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_sync  (in_sync),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/framed_parity_chk_tb_top.sv
module framed_parity_chk_tb_top;
  localparam int  FB       = 8;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sync  = 1'b0;
  logic in_bit   = 1'b0;
  logic done_o, err_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  bit m_open = 1'b0;
  int m_cnt  = 0;
  bit m_odd  = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  framed_parity_chk #(.FRAME_BITS(FB)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
    .in_bit(in_bit), .done_o(done_o), .err_o(err_o)
  );

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected outputs for one slot, per R3/R4/R6/R7/R8
  function automatic logic [1:0] model_step(input bit v, input bit s, input bit b);
    logic [1:0] r = 2'b00;
    if (v && s) begin
      m_open = 1'b1; m_cnt = 0; m_odd = 1'b0;
    end else if (v && m_open) begin
      m_odd = m_odd ^ b;
      m_cnt++;
      if (m_cnt == FB) begin
        r = {1'b1, m_odd};
        m_open = 1'b0; m_cnt = 0;
      end
    end
    return r;
  endfunction

  task automatic slot(input bit v, input bit s, input bit b, input string tag);
    logic [1:0] e;
    e = model_step(v, s, b);
    @(negedge clk);
    in_valid = v; in_sync = s; in_bit = b;
    @(posedge clk);
    #1;
    check_bit(tag, "done_o", done_o, e[1]);
    check_bit(tag, "err_o",  err_o,  e[0]);
  endtask

  task automatic send_frame(input logic [FB-1:0] payload, input int gap, input string tag);
    slot(1, 1, 0, tag);
    for (int i = 0; i < FB; i++) begin
      for (int g = 0; g < gap; g++) slot(0, (g % 2) == 0, 1, tag);
      slot(1, 0, payload[i], tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) begin
      @(posedge clk);
      #1;
      check_bit("R1", "done_o", done_o, 1'b0);
      check_bit("R1", "err_o",  err_o,  1'b0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: data before the first sync is ignored
    for (int i = 0; i < 12; i++) slot(1, 0, 1, "R2");

    // R3/R4: even payload, then odd payload
    send_frame(8'b0100_0100, 0, "R3");
    send_frame(8'b0001_0101, 0, "R4");
    send_frame(8'b0000_0000, 0, "R4");
    send_frame(8'b1111_1111, 0, "R4");
    send_frame(8'b1000_0000, 0, "R5");

    // R6: idle gaps (with sync and bit toggling) inside a frame
    send_frame(8'b0010_0000, 2, "R6");
    send_frame(8'b0110_0000, 1, "R6");

    // R7: resync after five payload bits, then a full frame
    slot(1, 1, 0, "R7");
    for (int i = 0; i < 5; i++) slot(1, 0, 1, "R7");
    send_frame(8'b0000_0011, 0, "R7");
    // R7: resync exactly where the last payload slot is due
    slot(1, 1, 0, "R7");
    for (int i = 0; i < FB - 1; i++) slot(1, 0, 1, "R7");
    slot(1, 1, 1, "R7");
    for (int i = 0; i < FB; i++) slot(1, 0, i == 3, "R7");

    // R8: stray data after a frame end
    for (int i = 0; i < 11; i++) slot(1, 0, 1, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v, s, b;
      v = ($urandom % 5) != 0;
      s = ($urandom % 14) == 0;
      b = $urandom % 2;
      slot(v, s, b, "R4");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule